// File: doc/BRIEF.md
# GPIO Line Interrupt Event Detector

This block watches a bank of general-purpose input lines and raises one interrupt when a line shows the event it was programmed for. Each input first passes through a flip-flop synchronizer. All detection works on the synchronized value, compared with a copy delayed by one clock. A line in default mode reports any change of level. When extended detection is enabled for a line, two more per-line bits pick rising edge, falling edge, high level or low level. The mode bits sit in set/clear register pairs, and each pair has a read-only view of the current bits.

A detected event latches into a pending register. A read of that register returns its contents and clears them. A bit is cleared only if the read returned it set, so an event that arrives in the same cycle as the read is kept. A line in level mode whose level is still active sets its bit again at once, so its interrupt stays up across reads until the input changes. A per-line mask, also held in a set/clear pair, chooses which pending bits drive the single interrupt output.

Top module: `gpio_evt_irq`

## Requirements
- R1: After reset, the pending, mask, extended-enable, kind and polarity registers all read zero, and `irq` is low.
- R2: In default mode (extended detection off for the line), any change of the synchronized input sets that line's pending bit. The bit reads as set after the third rising edge, counting the edge that first samples the new pin level. The kind and polarity bits have no effect in this mode.
- R3: Each set/clear pair behaves the same way. Writing to the set address sets the bits that are 1 in the write data. Writing to the clear address clears them. Zero bits leave the state unchanged, and the pair's status address returns the current bits.
- R4: With extended detection on, kind = edge (0) and polarity = 1, only a 0-to-1 transition of the synchronized input sets the pending bit.
- R5: With extended detection on, kind = edge (0) and polarity = 0, only a 1-to-0 transition sets the pending bit.
- R6: With extended detection on, kind = level (1) and polarity = 1, the pending bit is set in every cycle the synchronized input is high. A status read therefore does not leave it clear while the input stays high. Once the input is low and one read has been made, the bit stays clear.
- R7: With extended detection on, kind = level (1) and polarity = 0, the pending bit is set in every cycle the synchronized input is low.
- R8: A read (`reg_re`) of the pending address returns the current pending bits combinationally in that cycle. At the following edge it clears exactly the returned bits. An event detected in that same cycle still sets its bit.
- R9: `irq` is the OR over all lines of pending AND mask. It updates combinationally from the registers, so it follows the clock edge that changes either of them.
- R10: Register addresses (`reg_addr`) are: 0 mask set, 1 mask clear, 2 mask status, 3 pending (read to clear), 4 extended-enable set, 5 extended-enable clear, 6 extended-enable status, 7 select edge (clears kind bit), 8 select level (sets kind bit), 9 kind status, 10 select falling/low (clears polarity bit), 11 select rising/high (sets polarity bit), 12 polarity status. All other addresses read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pin_in | input | N_LINES | Raw asynchronous input lines |
| reg_we | input | 1 | Register write strobe |
| reg_re | input | 1 | Register read strobe (needed for read-to-clear) |
| reg_addr | input | 4 | Register address |
| reg_wdata | input | N_LINES | Write data, one bit per line |
| reg_rdata | output | N_LINES | Combinational read data |
| irq | output | 1 | Combined masked interrupt |

## Verification
A pending-register read and a newly detected event can fall in the same clock cycle. The bench provokes this by toggling a default-mode line exactly two edges before a read. The read is made in the cycle where the synchronized change first shows up as an event. That read must return the bit clear, and the next read must return it set, which shows the clear touched only the returned bits. The level-mode case, where the read and the re-set happen in every cycle, is checked by repeated reads of a held-high line, then reads after the line is released.

// File: rtl/gpio_evt_pkg.sv
package gpio_evt_pkg;
   localparam int REG_AW = 4;

   typedef enum logic [REG_AW-1:0] {
      A_MASK_ON   = 4'd0,
      A_MASK_OFF  = 4'd1,
      A_MASK_STAT = 4'd2,
      A_PEND      = 4'd3,
      A_XM_ON     = 4'd4,
      A_XM_OFF    = 4'd5,
      A_XM_STAT   = 4'd6,
      A_KIND_EDGE = 4'd7,
      A_KIND_LVL  = 4'd8,
      A_KIND_STAT = 4'd9,
      A_POL_LO    = 4'd10,
      A_POL_HI    = 4'd11,
      A_POL_STAT  = 4'd12
   } gpio_reg_e;
endpackage

// File: rtl/gpio_evt_sync.sv
module gpio_evt_sync #(
   parameter int W      = 32,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] raw,
   output logic [W-1:0] cur,
   output logic [W-1:0] prev
);
   logic [W-1:0] chain [STAGES];

   for (genvar k = 0; k < STAGES; k++) begin : g_stage
      if (k == 0) begin : g_first
         always_ff @(posedge clk) begin
            if (!rst_n) chain[k] <= '0;
            else        chain[k] <= raw;
         end
      end else begin : g_next
         always_ff @(posedge clk) begin
            if (!rst_n) chain[k] <= '0;
            else        chain[k] <= chain[k-1];
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) prev <= '0;
      else        prev <= chain[STAGES-1];
   end

   assign cur = chain[STAGES-1];
endmodule

// File: rtl/gpio_evt_setclr.sv
module gpio_evt_setclr #(
   parameter int W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         set_stb,
   input  logic         clr_stb,
   input  logic [W-1:0] wdata,
   output logic [W-1:0] q
);
   logic [W-1:0] set_m, clr_m;

   assign set_m = set_stb ? wdata : '0;
   assign clr_m = clr_stb ? wdata : '0;

   always_ff @(posedge clk) begin
      if (!rst_n) q <= '0;
      else        q <= (q | set_m) & ~clr_m;
   end
endmodule

// File: rtl/gpio_evt_detect.sv
module gpio_evt_detect #(
   parameter int W = 32
) (
   input  logic [W-1:0] cur,
   input  logic [W-1:0] prev,
   input  logic [W-1:0] xen,
   input  logic [W-1:0] kind,
   input  logic [W-1:0] pol,
   output logic [W-1:0] evt
);
   for (genvar i = 0; i < W; i++) begin : g_line
      logic rise, fall, lvl, edg;
      assign rise = cur[i] & ~prev[i];
      assign fall = ~cur[i] & prev[i];
      assign lvl  = pol[i] ? cur[i] : ~cur[i];
      assign edg  = pol[i] ? rise : fall;
      assign evt[i] = xen[i] ? (kind[i] ? lvl : edg) : (cur[i] ^ prev[i]);
   end
endmodule

// File: rtl/gpio_evt_irq.sv
module gpio_evt_irq
   import gpio_evt_pkg::*;
#(
   parameter int N_LINES     = 32,
   parameter int SYNC_STAGES = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [N_LINES-1:0] pin_in,
   input  logic               reg_we,
   input  logic               reg_re,
   input  logic [REG_AW-1:0]  reg_addr,
   input  logic [N_LINES-1:0] reg_wdata,
   output logic [N_LINES-1:0] reg_rdata,
   output logic               irq
);
   if (N_LINES < 1) begin : g_bad_lines
      $error("gpio_evt_irq: N_LINES must be at least 1");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("gpio_evt_irq: SYNC_STAGES must be at least 2");
   end

   logic [N_LINES-1:0] cur, prev, evt;
   logic [N_LINES-1:0] mask_q, xen_q, kind_q, pol_q, status_q;
   logic               rd_pend;

   gpio_evt_sync #(.W(N_LINES), .STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .raw(pin_in), .cur(cur), .prev(prev)
   );

   gpio_evt_setclr #(.W(N_LINES)) u_mask (
      .clk(clk), .rst_n(rst_n),
      .set_stb(reg_we && reg_addr == A_MASK_ON),
      .clr_stb(reg_we && reg_addr == A_MASK_OFF),
      .wdata(reg_wdata), .q(mask_q)
   );

   gpio_evt_setclr #(.W(N_LINES)) u_xen (
      .clk(clk), .rst_n(rst_n),
      .set_stb(reg_we && reg_addr == A_XM_ON),
      .clr_stb(reg_we && reg_addr == A_XM_OFF),
      .wdata(reg_wdata), .q(xen_q)
   );

   gpio_evt_setclr #(.W(N_LINES)) u_kind (
      .clk(clk), .rst_n(rst_n),
      .set_stb(reg_we && reg_addr == A_KIND_LVL),
      .clr_stb(reg_we && reg_addr == A_KIND_EDGE),
      .wdata(reg_wdata), .q(kind_q)
   );

   gpio_evt_setclr #(.W(N_LINES)) u_pol (
      .clk(clk), .rst_n(rst_n),
      .set_stb(reg_we && reg_addr == A_POL_HI),
      .clr_stb(reg_we && reg_addr == A_POL_LO),
      .wdata(reg_wdata), .q(pol_q)
   );

   gpio_evt_detect #(.W(N_LINES)) u_det (
      .cur(cur), .prev(prev), .xen(xen_q), .kind(kind_q), .pol(pol_q),
      .evt(evt)
   );

   assign rd_pend = reg_re && (reg_addr == A_PEND);

   always_ff @(posedge clk) begin
      if (!rst_n) status_q <= '0;
      else        status_q <= (status_q & ~(rd_pend ? status_q : '0)) | evt;
   end

   always_comb begin
      case (reg_addr)
         A_MASK_STAT: reg_rdata = mask_q;
         A_PEND:      reg_rdata = status_q;
         A_XM_STAT:   reg_rdata = xen_q;
         A_KIND_STAT: reg_rdata = kind_q;
         A_POL_STAT:  reg_rdata = pol_q;
         default:     reg_rdata = '0;
      endcase
   end

   assign irq = |(status_q & mask_q);
endmodule

// File: rtl/gpio_evt_irq_chk.sv
module gpio_evt_irq_chk
   import gpio_evt_pkg::*;
#(
   parameter int N_LINES = 32
) (
   input logic               clk,
   input logic               rst_n,
   input logic               reg_we,
   input logic               reg_re,
   input logic [REG_AW-1:0]  reg_addr,
   input logic [N_LINES-1:0] reg_wdata,
   input logic [N_LINES-1:0] reg_rdata,
   input logic               irq,
   input logic [N_LINES-1:0] evt,
   input logic [N_LINES-1:0] status_q,
   input logic [N_LINES-1:0] mask_q
);
   // R8
   rdclr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_re && reg_addr == A_PEND) |=>
      ((status_q & $past(reg_rdata) & ~$past(evt)) == '0));

   // R2
   evt_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (|evt) |=> ((status_q & $past(evt)) == $past(evt)));

   // R8
   no_spurious_chk: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((status_q & ~$past(status_q) & ~$past(evt)) == '0));

   // R9
   mask_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_we && reg_addr == A_MASK_OFF && (&reg_wdata)) |=> !irq);

   // R3
   mask_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_we && reg_addr == A_MASK_ON) |=>
      ((mask_q & $past(reg_wdata)) == $past(reg_wdata)));
endmodule

bind gpio_evt_irq gpio_evt_irq_chk #(.N_LINES(N_LINES)) u_chk (
   .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_re(reg_re),
   .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
   .irq(irq), .evt(evt), .status_q(status_q), .mask_q(mask_q)
);

// File: tb/gpio_evt_irq_tb.sv
module gpio_evt_irq_tb;
   localparam int N = 32;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [N-1:0]  pin_in = '0;
   logic          reg_we = 1'b0;
   logic          reg_re = 1'b0;
   logic [3:0]    reg_addr = '0;
   logic [N-1:0]  reg_wdata = '0;
   logic [N-1:0]  reg_rdata;
   logic          irq;
   int            total = 0;
   int            bad = 0;

   always #5 clk = ~clk;

   gpio_evt_irq #(.N_LINES(N), .SYNC_STAGES(2)) u_dut (
      .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .reg_we(reg_we),
      .reg_re(reg_re), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
      .reg_rdata(reg_rdata), .irq(irq)
   );

   // vector bits: {xen, kind, pol, start level, end level, expected pending}
   localparam logic [5:0] VEC [13] = '{
      6'b000_01_1, 6'b000_10_1, 6'b000_11_0,   // R2 default: any change
      6'b011_11_0,                             // R2 kind/pol ignored
      6'b101_01_1, 6'b101_10_0,                // R4 rising
      6'b100_10_1, 6'b100_01_0,                // R5 falling
      6'b111_01_1, 6'b111_00_0,                // R6 high level
      6'b110_10_1, 6'b110_11_0, 6'b110_00_1    // R7 low level
   };

   task automatic chk(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [3:0] a, input logic [N-1:0] d);
      @(negedge clk); reg_we = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk); reg_we = 1'b0; reg_wdata = '0;
   endtask

   task automatic rd(input logic [3:0] a, output logic [N-1:0] d);
      @(negedge clk); reg_re = 1'b1; reg_addr = a; #1 d = reg_rdata;
      @(negedge clk); reg_re = 1'b0;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      total++; bad++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin : main
      logic [N-1:0] v;
      logic [N-1:0] m;
      idle(3);
      rst_n = 1'b1;
      idle(2);

      // R1 reset state
      rd(4'd3, v);  chk("R1 pending", v, '0);
      rd(4'd2, v);  chk("R1 mask", v, '0);
      rd(4'd6, v);  chk("R1 xen", v, '0);
      rd(4'd9, v);  chk("R1 kind", v, '0);
      rd(4'd12, v); chk("R1 pol", v, '0);
      chk("R1 irq", {31'd0, irq}, '0);
      rd(4'd15, v); chk("R10 unmapped", v, '0);

      // R3 set/clear pairs, zero bits leave state alone
      wr(4'd8, 32'h0000_00F0); rd(4'd9, v); chk("R3 kind set", v, 32'h0000_00F0);
      wr(4'd7, 32'h0000_0010); rd(4'd9, v); chk("R3 kind clr", v, 32'h0000_00E0);
      wr(4'd8, 32'h0);         rd(4'd9, v); chk("R3 kind zero", v, 32'h0000_00E0);
      wr(4'd11, 32'h8000_0001); rd(4'd12, v); chk("R3 pol set", v, 32'h8000_0001);
      wr(4'd10, 32'h8000_0000); rd(4'd12, v); chk("R3 pol clr", v, 32'h0000_0001);
      wr(4'd4, 32'h0000_0300); rd(4'd6, v); chk("R3 xen set", v, 32'h0000_0300);
      wr(4'd5, 32'hFFFF_FFFF); rd(4'd6, v); chk("R3 xen clr", v, 32'h0);
      wr(4'd7, 32'hFFFF_FFFF); wr(4'd10, 32'hFFFF_FFFF);

      // table walk, one line per vector
      for (int i = 0; i < 13; i++) begin
         logic [5:0] e;
         e = VEC[i];
         @(negedge clk); pin_in[i] = e[2];
         idle(4);
         wr(e[5] ? 4'd4 : 4'd5, 32'(1) << i);
         wr(e[4] ? 4'd8 : 4'd7, 32'(1) << i);
         wr(e[3] ? 4'd11 : 4'd10, 32'(1) << i);
         idle(4);
         rd(4'd3, v);
         @(negedge clk); pin_in[i] = e[1];
         idle(5);
         rd(4'd3, v);
         chk($sformatf("R2/R4/R5/R6/R7 vector %0d", i), {31'd0, v[i]}, {31'd0, e[0]});
      end

      // R9 mask gating of irq, line 20 default mode
      rd(4'd3, v);
      @(negedge clk); pin_in[20] = 1'b1;
      idle(5);
      chk("R9 irq masked off", {31'd0, irq}, '0);
      wr(4'd0, 32'h0010_0000);
      chk("R9 irq on", {31'd0, irq}, 32'd1);
      rd(4'd2, m); chk("R9 mask stat", m, 32'h0010_0000);
      wr(4'd1, 32'h0010_0000);
      chk("R9 irq off", {31'd0, irq}, '0);
      wr(4'd0, 32'h0010_0000);
      rd(4'd3, v);
      chk("R9 irq after clear", {31'd0, irq}, '0);
      wr(4'd1, 32'hFFFF_FFFF);

      // R8 plain read clears
      @(negedge clk); pin_in[20] = 1'b0;
      idle(5);
      rd(4'd3, v); chk("R8 first read", {31'd0, v[20]}, 32'd1);
      rd(4'd3, v); chk("R8 second read", {31'd0, v[20]}, '0);

      // R8 event lands in the same cycle as the read
      @(negedge clk); pin_in[21] = 1'b1;
      @(negedge clk);
      @(negedge clk); reg_re = 1'b1; reg_addr = 4'd3; #1 v = reg_rdata;
      @(negedge clk); reg_re = 1'b0;
      chk("R8 same-cycle read", {31'd0, v[21]}, '0);
      rd(4'd3, v); chk("R8 event kept", {31'd0, v[21]}, 32'd1);

      // R6 high level persists across reads, then stops
      wr(4'd4, 32'h0040_0000); wr(4'd8, 32'h0040_0000); wr(4'd11, 32'h0040_0000);
      wr(4'd0, 32'h0040_0000);
      @(negedge clk); pin_in[22] = 1'b1;
      idle(4);
      rd(4'd3, v); chk("R6 level read 1", {31'd0, v[22]}, 32'd1);
      rd(4'd3, v); chk("R6 level read 2", {31'd0, v[22]}, 32'd1);
      chk("R6 irq held", {31'd0, irq}, 32'd1);
      @(negedge clk); pin_in[22] = 1'b0;
      idle(4);
      rd(4'd3, v);
      rd(4'd3, v); chk("R6 released", {31'd0, v[22]}, '0);
      chk("R6 irq drops", {31'd0, irq}, '0);

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule